// File: doc/BRIEF.md
# Paired Single-Precision to Integer Saturating Converter

The block converts two IEEE-754 single-precision values, packed side by side in a 64-bit operand, into two 32-bit signed integers. Each 32-bit lane is converted on its own, with the fraction truncated toward zero. An 8-bit opcode suffix picks the target range, and both lanes use it. Suffix 1Dh clamps to the full signed 32-bit range. Suffix 1Ch clamps to the signed 16-bit range and sign-extends that result to fill the 32-bit lane.

An operand that comes with a valid strobe and a known suffix is accepted. Its result appears with a valid strobe exactly two clock edges later. A new operand may be accepted on every cycle. A strobe that comes with any other suffix is dropped and produces no result.

Top module: `pfcvt_sat`

## Requirements
- R1: Lane n of the source (bits 32n+31 down to 32n) maps only to lane n of the result. Each lane is converted independently of the other.
- R2: With suffix 1Dh, a finite input whose magnitude is between 1.0 and 2^31 gives its integer part, truncated toward zero, as a 32-bit two's-complement value.
- R3: With suffix 1Dh, +infinity and finite values at or above +2^31 give 7FFFFFFFh. -infinity and values at or below -2^31 give 80000000h.
- R4: With suffix 1Ch, the truncated value is clamped to the range -32768 to 32767 and then sign-extended to 32 bits. This gives 00007FFFh at the top and FFFF8000h at the bottom. Infinities saturate by sign in the same way.
- R5: A NaN input (exponent all ones, fraction nonzero) gives the negative limit of the selected mode: 80000000h for suffix 1Dh and FFFF8000h for suffix 1Ch.
- R6: Any input with magnitude below 1.0 gives 0 in both modes. This includes +0, -0 and denormals.
- R7: A result and out_valid appear exactly two rising edges after the edge that accepts the operand. Operands accepted on consecutive cycles give results on consecutive cycles.
- R8: A valid strobe with a suffix other than 1Ch or 1Dh is not accepted, and out_valid stays low for that strobe.
- R9: While reset is asserted, and on the first cycle after it is released, out_valid is 0 and out_result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_suffix | input | 8 | Opcode suffix that selects the mode (1Dh or 1Ch) |
| in_src | input | 64 | Two packed single-precision values |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Two packed 32-bit signed integers |

## Verification
The bench builds the block with its default parameters. These are two lanes and the suffix codes 1Dh and 1Ch, so every class of input can be placed in either lane: small, in range, at the limits, infinite, NaN, below one and denormal. The same operand encodings are sent under both suffixes, so one input value exposes the 32-bit limits and the 16-bit limits side by side. A back-to-back pair and a rejected suffix exercise the fixed pipeline timing.

// File: rtl/pfcvt_pkg.sv
package pfcvt_pkg;

    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int EXP_BIAS = 127;
    localparam int MAG_W    = FP_W - 1;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_POS  = 2'd2,
        CLS_NEG  = 2'd3
    } val_cls_e;

    typedef enum logic {
        MODE_W32 = 1'b0,
        MODE_W16 = 1'b1
    } sat_mode_e;

    typedef struct packed {
        val_cls_e         cls;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } unpacked_t;

    localparam logic [FP_W-1:0] W32_MAX = 32'h7FFF_FFFF;
    localparam logic [FP_W-1:0] W32_MIN = 32'h8000_0000;
    localparam logic [FP_W-1:0] W16_MAX = 32'h0000_7FFF;
    localparam logic [FP_W-1:0] W16_MIN = 32'hFFFF_8000;

    function automatic logic is_sext16(input logic [FP_W-1:0] v);
        return (v[FP_W-1:15] == '0) || (v[FP_W-1:15] == '1);
    endfunction

endpackage

// File: rtl/pfcvt_unpack.sv
module pfcvt_unpack
    import pfcvt_pkg::*;
(
    input  logic [FP_W-1:0] fp,
    output unpacked_t       up
);
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [FRAC_W-1:0] fr;
    logic [EXP_W-1:0] k;
    logic [MAG_W-1:0] sig;

    assign sgn = fp[FP_W-1];
    assign ex  = fp[FP_W-2 -: EXP_W];
    assign fr  = fp[FRAC_W-1:0];
    assign k   = ex - EXP_W'(EXP_BIAS);
    assign sig = {{(MAG_W-FRAC_W-1){1'b0}}, 1'b1, fr};

    always_comb begin
        up.sign = sgn;
        up.mag  = '0;
        up.cls  = CLS_ZERO;
        if (ex == '1) begin
            up.cls = (fr != '0 || sgn) ? CLS_NEG : CLS_POS;
        end else if (ex < EXP_W'(EXP_BIAS)) begin
            up.cls = CLS_ZERO;
        end else if (k >= EXP_W'(MAG_W)) begin
            up.cls = sgn ? CLS_NEG : CLS_POS;
        end else begin
            up.cls = CLS_NUM;
            if (k >= EXP_W'(FRAC_W))
                up.mag = sig << (k - EXP_W'(FRAC_W));
            else
                up.mag = sig >> (EXP_W'(FRAC_W) - k);
        end
    end
endmodule

// File: rtl/pfcvt_clamp.sv
module pfcvt_clamp
    import pfcvt_pkg::*;
(
    input  unpacked_t       up,
    input  sat_mode_e       mode,
    output logic [FP_W-1:0] res
);
    localparam logic [MAG_W-1:0] LIM16_P = MAG_W'(32767);
    localparam logic [MAG_W-1:0] LIM16_N = MAG_W'(32768);

    logic [FP_W-1:0] signed_val;

    assign signed_val = up.sign ? (FP_W'(0) - {1'b0, up.mag}) : {1'b0, up.mag};

    always_comb begin
        unique case (up.cls)
            CLS_ZERO: res = '0;
            CLS_POS:  res = (mode == MODE_W32) ? W32_MAX : W16_MAX;
            CLS_NEG:  res = (mode == MODE_W32) ? W32_MIN : W16_MIN;
            default: begin
                if (mode == MODE_W32)
                    res = signed_val;
                else if (!up.sign && up.mag > LIM16_P)
                    res = W16_MAX;
                else if (up.sign && up.mag > LIM16_N)
                    res = W16_MIN;
                else
                    res = signed_val;
            end
        endcase
    end
endmodule

// File: rtl/pfcvt_sat.sv
module pfcvt_sat
    import pfcvt_pkg::*;
#(
    parameter int          LANES      = 2,
    parameter logic [7:0]  SUFFIX_W32 = 8'h1D,
    parameter logic [7:0]  SUFFIX_W16 = 8'h1C
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [7:0]           in_suffix,
    input  logic [LANES*32-1:0]  in_src,
    output logic                 out_valid,
    output logic [LANES*32-1:0]  out_result
);
    localparam int DATA_W = LANES * FP_W;

    logic      known;
    logic      accept;
    sat_mode_e in_mode;

    assign known   = (in_suffix == SUFFIX_W32) || (in_suffix == SUFFIX_W16);
    assign accept  = in_valid && known;
    assign in_mode = (in_suffix == SUFFIX_W16) ? MODE_W16 : MODE_W32;

    logic      s1_valid;
    sat_mode_e s1_mode;
    unpacked_t s1_up  [LANES];
    unpacked_t up_c   [LANES];
    logic [FP_W-1:0] res_c [LANES];
    logic [DATA_W-1:0] res_flat;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pfcvt_unpack u_unpack (
            .fp (in_src[g*FP_W +: FP_W]),
            .up (up_c[g])
        );

        pfcvt_clamp u_clamp (
            .up   (s1_up[g]),
            .mode (s1_mode),
            .res  (res_c[g])
        );

        assign res_flat[g*FP_W +: FP_W] = res_c[g];

        always_ff @(posedge clk) begin
            if (rst)
                s1_up[g] <= '0;
            else if (accept)
                s1_up[g] <= up_c[g];
        end

        // R4: 16-bit mode results are always sign extensions of a 16-bit value
        a_r4_sext_range: assert property (@(posedge clk) disable iff (rst)
            (s1_valid && s1_mode == MODE_W16) |=> is_sext16(out_result[g*FP_W +: FP_W]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid   <= 1'b0;
            s1_mode    <= MODE_W32;
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            s1_valid  <= accept;
            if (accept)
                s1_mode <= in_mode;
            out_valid <= s1_valid;
            if (s1_valid)
                out_result <= res_flat;
        end
    end

    // R7: an accepted operand moves through the first stage on the next edge
    a_r7_stage_one: assert property (@(posedge clk) disable iff (rst)
        accept |=> s1_valid);

    // R7: the first stage feeds the output strobe one edge later
    a_r7_stage_two: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid);

    // R7: no output strobe without a preceding first-stage entry
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !out_valid);

    // R8: a strobe with an unknown suffix never enters the pipeline
    a_r8_reject: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !known) |=> !s1_valid);

    // R9: the outputs hold their cleared values one edge after a reset cycle
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));

endmodule

// File: tb/pfcvt_sat_tb_top.sv
module pfcvt_sat_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_suffix;
    logic [63:0] in_src;
    logic        out_valid;
    logic [63:0] out_result;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] SFX32 = 8'h1D;
    localparam logic [7:0] SFX16 = 8'h1C;

    always #10 clk = ~clk;

    pfcvt_sat dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_suffix  (in_suffix),
        .in_src     (in_src),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one operand, then sample after the second edge.
    task automatic convert(input string req, input logic [7:0] sfx,
                           input logic [31:0] hi, input logic [31:0] lo,
                           input logic [31:0] exp_hi, input logic [31:0] exp_lo);
        @(negedge clk);
        in_valid = 1'b1; in_suffix = sfx; in_src = {hi, lo};
        @(negedge clk);
        in_valid = 1'b0;
        check1(req, out_valid, 1'b0);
        @(negedge clk);
        check1(req, out_valid, 1'b1);
        check64(req, out_result, {exp_hi, exp_lo});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_suffix = 8'h00; in_src = '0;
        repeat (3) @(negedge clk);
        check1("R9", out_valid, 1'b0);
        check64("R9", out_result, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check1("R9", out_valid, 1'b0);
        check64("R9", out_result, 64'h0);
    endtask

    task automatic t_basic;
        convert("R2", SFX32, 32'hC030_0000, 32'h3FC0_0000, 32'hFFFF_FFFE, 32'h0000_0001);
        convert("R2", SFX32, 32'hC7C3_5000, 32'h47C3_5000, 32'hFFFE_7960, 32'h0001_86A0);
        convert("R2", SFX32, 32'h3F80_0000, 32'h4EFF_FFFF, 32'h0000_0001, 32'h7FFF_FF80);
        convert("R1", SFX32, 32'h0000_0000, 32'h7F80_0000, 32'h0000_0000, 32'h7FFF_FFFF);
    endtask

    task automatic t_sat32;
        convert("R3", SFX32, 32'hCF00_0000, 32'h4F00_0000, 32'h8000_0000, 32'h7FFF_FFFF);
        convert("R3", SFX32, 32'hFF80_0000, 32'h7F80_0000, 32'h8000_0000, 32'h7FFF_FFFF);
        convert("R3", SFX32, 32'hD000_0000, 32'h5F00_0000, 32'h8000_0000, 32'h7FFF_FFFF);
    endtask

    task automatic t_sat16;
        convert("R4", SFX16, 32'hC7C3_5000, 32'h47C3_5000, 32'hFFFF_8000, 32'h0000_7FFF);
        convert("R4", SFX16, 32'hC700_0000, 32'h46FF_FE00, 32'hFFFF_8000, 32'h0000_7FFF);
        convert("R4", SFX16, 32'hC700_0100, 32'h4700_0000, 32'hFFFF_8000, 32'h0000_7FFF);
        convert("R4", SFX16, 32'hC030_0000, 32'h3FC0_0000, 32'hFFFF_FFFE, 32'h0000_0001);
        convert("R4", SFX16, 32'hFF80_0000, 32'h7F80_0000, 32'hFFFF_8000, 32'h0000_7FFF);
        convert("R2", SFX32, 32'hC700_0100, 32'h4700_0000, 32'hFFFF_7FFF, 32'h0000_8000);
    endtask

    task automatic t_nan;
        convert("R5", SFX32, 32'hFFC0_0000, 32'h7FC0_0000, 32'h8000_0000, 32'h8000_0000);
        convert("R5", SFX16, 32'h7F80_0001, 32'h3F80_0000, 32'hFFFF_8000, 32'h0000_0001);
    endtask

    task automatic t_small;
        convert("R6", SFX32, 32'hBF40_0000, 32'h3F00_0000, 32'h0, 32'h0);
        convert("R6", SFX32, 32'h8000_0000, 32'h0000_0001, 32'h0, 32'h0);
        convert("R6", SFX16, 32'h807F_FFFF, 32'h0000_0000, 32'h0, 32'h0);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        in_valid = 1'b1; in_suffix = SFX32; in_src = {32'hC030_0000, 32'h3FC0_0000};
        @(negedge clk);
        in_suffix = SFX16; in_src = {32'hC7C3_5000, 32'h47C3_5000};
        @(negedge clk);
        in_valid = 1'b0;
        check1("R7", out_valid, 1'b1);
        check64("R7", out_result, {32'hFFFF_FFFE, 32'h0000_0001});
        @(negedge clk);
        check1("R7", out_valid, 1'b1);
        check64("R7", out_result, {32'hFFFF_8000, 32'h0000_7FFF});
        @(negedge clk);
        check1("R7", out_valid, 1'b0);
    endtask

    task automatic t_reject;
        @(negedge clk);
        in_valid = 1'b1; in_suffix = 8'h9E; in_src = {32'h3F80_0000, 32'h3F80_0000};
        @(negedge clk);
        in_valid = 1'b0;
        check1("R8", out_valid, 1'b0);
        @(negedge clk);
        check1("R8", out_valid, 1'b0);
        @(negedge clk);
        check1("R8", out_valid, 1'b0);
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_sat32();
        t_sat16();
        t_nan();
        t_small();
        t_back_to_back();
        t_reject();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule